// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the register-and-ALU half of a simple processor in which every transfer crosses a single shared internal bus. It holds a program counter, an instruction register, a memory address register, a memory data register, a scratch register, eight general registers, an operand latch, a combinational ALU and a result register. An external sequencer drives a flat set of enable pins each step. A drive enable places one register on the bus. A load enable captures the bus into a register at the next rising clock edge.

The ALU takes its second operand straight from the bus. Its first operand comes from a mux that picks either the operand latch or the constant 4. Its result can only be captured into the result register, which is how the program counter steps by one 32-bit word in a byte-addressed space. The memory data register has two load paths and two drive paths: one pair for the internal bus, one pair for the memory data lines.

The memory side is a request/completion handshake. A read or write command raises the matching strobe. The strobe stays high until the memory reports completion, and it drops on the clock edge that samples completion. The sequencer waits for completion before capturing read data or changing the write data. The current bus value and a bus-conflict flag are brought out so that the sequencer and the bench can see each step.

Top module: `sbus_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, every register is cleared to zero and both memory strobes go low.
- R2: `bus_q` equals the value of the single source whose drive enable is high. It is zero when no drive enable is high.
- R3: `bus_err` is high in any cycle where two or more drive enables are high, and low otherwise. Drive enables are `pc_drv`, `ir_drv`, `mdr_drv`, `z_drv`, `tmp_drv` and each bit of `gpr_drv`.
- R4: A register whose load enable is high captures `bus_q` at the rising edge. Otherwise it keeps its value. Bit i of `gpr_ld` and `gpr_drv` selects general register i.
- R5: The ALU first operand is the constant 4 when `sel_four` is high, and the operand latch otherwise. The second operand is `bus_q`. The result is stored only in the result register, on `z_ld`.
- R6: ALU operations are taken modulo 2^32. `alu_op` 00 gives A+B+`carry_in`, 01 gives A-B-`carry_in`, 10 gives A XOR B, and 11 gives A OR B.
- R7: `mem_addr` always shows the memory address register.
- R8: `mdr_mem_ld` loads the memory data register from `mem_rdata`, and takes priority over `mdr_ld`.
- R9: `mem_wdata` shows the memory data register while `mdr_mem_drv` is high, and is zero otherwise.
- R10: `rd_cmd` (or `wr_cmd`) sets `mem_rd` (or `mem_wr`) at the next edge. The strobe holds until an edge where `mem_done` is high and no new command is given.
- R11: `ir_q` always shows the instruction register.
- R12: A fetch sequence fetches the word at the program counter address into the instruction register and advances the program counter by 4. The sequence is: PC drive with MAR load, read, constant 4, add and Z load; then Z drive with PC load; then the memory load of MDR; then MDR drive with IR load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pc_ld | input | 1 | Load program counter from bus |
| pc_drv | input | 1 | Drive program counter onto bus |
| ir_ld | input | 1 | Load instruction register from bus |
| ir_drv | input | 1 | Drive instruction register onto bus |
| mar_ld | input | 1 | Load memory address register from bus |
| mdr_ld | input | 1 | Load memory data register from bus |
| mdr_drv | input | 1 | Drive memory data register onto bus |
| mdr_mem_ld | input | 1 | Load memory data register from memory data lines |
| mdr_mem_drv | input | 1 | Drive memory data register onto memory data lines |
| tmp_ld | input | 1 | Load scratch register from bus |
| tmp_drv | input | 1 | Drive scratch register onto bus |
| y_ld | input | 1 | Load ALU operand latch from bus |
| z_ld | input | 1 | Capture ALU result |
| z_drv | input | 1 | Drive result register onto bus |
| gpr_ld | input | 8 | One-hot general register load enables |
| gpr_drv | input | 8 | One-hot general register drive enables |
| alu_op | input | 2 | ALU operation select |
| carry_in | input | 1 | ALU carry/borrow input |
| sel_four | input | 1 | Select constant 4 as first ALU operand |
| rd_cmd | input | 1 | Start memory read |
| wr_cmd | input | 1 | Start memory write |
| mem_done | input | 1 | Memory operation completed |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| ir_q | output | 32 | Instruction register value |
| bus_q | output | 32 | Internal bus value |
| bus_err | output | 1 | More than one bus driver this cycle |

## Verification
The load checks assume a well-formed sequencer, so they are guarded by `bus_err`: a load in a cycle with more than one driver is left unchecked. The strobe properties assume the memory reports completion only while a strobe is high. They also assume `rd_cmd` and `wr_cmd` are never raised together. The bench keeps to these assumptions. It raises a single command per access and leaves the enables idle while it waits for completion. Its behavioural memory asserts completion only against a live strobe, after a latency that changes between accesses. Two drivers are enabled together only in the one step that tests the conflict flag, and no register loads in that step.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_XOR = 2'b10,
    OP_OR  = 2'b11
  } alu_op_e;

  localparam int unsigned WORD_STEP = 4;
endpackage

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter int W    = 32,
  parameter int NREG = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREG-1:0] ld,
  input  logic [NREG-1:0] drv,
  input  logic [W-1:0]    bus_in,
  output logic [W-1:0]    drv_val
);
  logic [W-1:0] regs  [NREG];
  logic [W-1:0] gated [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)        regs[i] <= '0;
      else if (ld[i]) regs[i] <= bus_in;
    end
    assign gated[i] = drv[i] ? regs[i] : '0;
  end

  always_comb begin
    drv_val = '0;
    for (int i = 0; i < NREG; i++) drv_val = drv_val | gated[i];
  end
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
  import sbus_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic         cin,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic [W-1:0] cin_w;
  assign cin_w = {{(W-1){1'b0}}, cin};

  always_comb begin
    unique case (op)
      OP_ADD: y = a + b + cin_w;
      OP_SUB: y = a - b - cin_w;
      OP_XOR: y = a ^ b;
      default: y = a | b;
    endcase
  end
endmodule

// File: rtl/sbus_memif.sv
module sbus_memif (
  input  logic clk,
  input  logic rst,
  input  logic rd_cmd,
  input  logic wr_cmd,
  input  logic done,
  output logic rd,
  output logic wr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd <= 1'b0;
      wr <= 1'b0;
    end else begin
      if (rd_cmd)    rd <= 1'b1;
      else if (done) rd <= 1'b0;
      if (wr_cmd)    wr <= 1'b1;
      else if (done) wr <= 1'b0;
    end
  end
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
  import sbus_pkg::*;
#(
  parameter int W    = 32,
  parameter int NREG = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pc_ld,
  input  logic            pc_drv,
  input  logic            ir_ld,
  input  logic            ir_drv,
  input  logic            mar_ld,
  input  logic            mdr_ld,
  input  logic            mdr_drv,
  input  logic            mdr_mem_ld,
  input  logic            mdr_mem_drv,
  input  logic            tmp_ld,
  input  logic            tmp_drv,
  input  logic            y_ld,
  input  logic            z_ld,
  input  logic            z_drv,
  input  logic [NREG-1:0] gpr_ld,
  input  logic [NREG-1:0] gpr_drv,
  input  logic [1:0]      alu_op,
  input  logic            carry_in,
  input  logic            sel_four,
  input  logic            rd_cmd,
  input  logic            wr_cmd,
  input  logic            mem_done,
  input  logic [W-1:0]    mem_rdata,
  output logic [W-1:0]    mem_addr,
  output logic [W-1:0]    mem_wdata,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [W-1:0]    ir_q,
  output logic [W-1:0]    bus_q,
  output logic            bus_err
);
  localparam int NDRV = NREG + 5;
  localparam logic [W-1:0] FOUR = W'(WORD_STEP);

  logic [W-1:0] pc_r, ir_r, mar_r, mdr_r, tmp_r, y_r, z_r;
  logic [W-1:0] gpr_val, alu_a, alu_y;
  logic [NDRV-1:0] drv_all;

  // Single shared bus: OR of gated sources
  assign bus_q = (pc_drv  ? pc_r  : '0)
               | (ir_drv  ? ir_r  : '0)
               | (mdr_drv ? mdr_r : '0)
               | (z_drv   ? z_r   : '0)
               | (tmp_drv ? tmp_r : '0)
               | gpr_val;

  assign drv_all = {gpr_drv, pc_drv, ir_drv, mdr_drv, z_drv, tmp_drv};
  assign bus_err = ($countones(drv_all) > 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_r  <= '0;
      ir_r  <= '0;
      mar_r <= '0;
      mdr_r <= '0;
      tmp_r <= '0;
      y_r   <= '0;
      z_r   <= '0;
    end else begin
      if (pc_ld)           pc_r  <= bus_q;
      if (ir_ld)           ir_r  <= bus_q;
      if (mar_ld)          mar_r <= bus_q;
      if (mdr_mem_ld)      mdr_r <= mem_rdata;
      else if (mdr_ld)     mdr_r <= bus_q;
      if (tmp_ld)          tmp_r <= bus_q;
      if (y_ld)            y_r   <= bus_q;
      if (z_ld)            z_r   <= alu_y;
    end
  end

  sbus_regfile #(.W(W), .NREG(NREG)) u_gpr (
    .clk    (clk),
    .rst    (rst),
    .ld     (gpr_ld),
    .drv    (gpr_drv),
    .bus_in (bus_q),
    .drv_val(gpr_val)
  );

  assign alu_a = sel_four ? FOUR : y_r;

  sbus_alu #(.W(W)) u_alu (
    .op (alu_op_e'(alu_op)),
    .cin(carry_in),
    .a  (alu_a),
    .b  (bus_q),
    .y  (alu_y)
  );

  sbus_memif u_mem (
    .clk   (clk),
    .rst   (rst),
    .rd_cmd(rd_cmd),
    .wr_cmd(wr_cmd),
    .done  (mem_done),
    .rd    (mem_rd),
    .wr    (mem_wr)
  );

  assign mem_addr  = mar_r;
  assign mem_wdata = mdr_mem_drv ? mdr_r : '0;
  assign ir_q      = ir_r;
endmodule

// File: rtl/sbus_datapath_chk.sv
module sbus_datapath_chk #(
  parameter int W    = 32,
  parameter int NREG = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            pc_drv,
  input logic            ir_ld,
  input logic            ir_drv,
  input logic            mar_ld,
  input logic            mdr_drv,
  input logic            mdr_mem_drv,
  input logic            tmp_drv,
  input logic            z_drv,
  input logic [NREG-1:0] gpr_drv,
  input logic            rd_cmd,
  input logic            wr_cmd,
  input logic            mem_done,
  input logic [W-1:0]    mem_addr,
  input logic [W-1:0]    mem_wdata,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic [W-1:0]    ir_q,
  input logic [W-1:0]    bus_q,
  input logic            bus_err
);
  logic none_drv;
  assign none_drv = !(pc_drv || ir_drv || mdr_drv || tmp_drv || z_drv || (|gpr_drv));

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (mem_addr == '0 && ir_q == '0 && !mem_rd && !mem_wr));

  assert_idle_bus_R2: assert property (@(posedge clk) disable iff (rst)
    none_drv |-> (bus_q == '0 && !bus_err));

  assert_ir_load_R4: assert property (@(posedge clk) disable iff (rst)
    (ir_ld && !bus_err) |=> (ir_q == $past(bus_q)));

  assert_ir_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !ir_ld |=> $stable(ir_q));

  assert_mar_addr_R7: assert property (@(posedge clk) disable iff (rst)
    (mar_ld && !bus_err) |=> (mem_addr == $past(bus_q)));

  assert_wdata_gate_R9: assert property (@(posedge clk) disable iff (rst)
    !mdr_mem_drv |-> (mem_wdata == '0));

  assert_rd_rise_R10: assert property (@(posedge clk) disable iff (rst)
    rd_cmd |=> mem_rd);

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_done) |=> mem_rd);

  assert_rd_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && mem_done && !rd_cmd) |=> !mem_rd);

  assert_wr_rise_R10: assert property (@(posedge clk) disable iff (rst)
    wr_cmd |=> mem_wr);
endmodule

bind sbus_datapath sbus_datapath_chk #(.W(W), .NREG(NREG)) u_chk (.*);

// File: tb/sbus_datapath_tb.sv
`timescale 1ns/1ps
module sbus_datapath_tb;
  localparam int W = 32;
  localparam int NREG = 8;
  localparam int WDOG_CYC = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pc_ld, pc_drv, ir_ld, ir_drv, mar_ld, mdr_ld, mdr_drv;
  logic mdr_mem_ld, mdr_mem_drv, tmp_ld, tmp_drv, y_ld, z_ld, z_drv;
  logic [NREG-1:0] gpr_ld, gpr_drv;
  logic [1:0] alu_op;
  logic carry_in, sel_four, rd_cmd, wr_cmd, mem_done;
  logic [W-1:0] mem_rdata, mem_addr, mem_wdata, ir_q, bus_q;
  logic mem_rd, mem_wr, bus_err;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  // behavioural memory with variable latency
  logic [W-1:0] mem [16];
  int lat = 0;
  int cnt = 0;
  assign mem_done  = (mem_rd || mem_wr) && (cnt >= lat);
  assign mem_rdata = mem[mem_addr[5:2]];
  always @(posedge clk) begin
    if (mem_wr && mem_done) mem[mem_addr[5:2]] <= mem_wdata;
    if (!(mem_rd || mem_wr)) cnt <= 0;
    else if (!mem_done)      cnt <= cnt + 1;
  end

  sbus_datapath #(.W(W), .NREG(NREG)) u_dut (.*);

  // op(2) cin(1) sel4(1) a(32) b(32) exp(32)
  localparam logic [99:0] VEC [8] = '{
    {2'b00, 1'b0, 1'b0, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C},
    {2'b00, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001},
    {2'b01, 1'b0, 1'b0, 32'h0000_000A, 32'h0000_0003, 32'h0000_0007},
    {2'b01, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF},
    {2'b10, 1'b0, 1'b0, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'h0FF0_0FF0},
    {2'b11, 1'b0, 1'b0, 32'h1234_0000, 32'h0000_5678, 32'h1234_5678},
    {2'b00, 1'b0, 1'b1, 32'h0000_1000, 32'h0000_0100, 32'h0000_0104},
    {2'b01, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0001, 32'h0000_0003}
  };

  task automatic idle();
    {pc_ld, pc_drv, ir_ld, ir_drv, mar_ld, mdr_ld, mdr_drv} = '0;
    {mdr_mem_ld, mdr_mem_drv, tmp_ld, tmp_drv, y_ld, z_ld, z_drv} = '0;
    gpr_ld = '0; gpr_drv = '0; alu_op = 2'b00;
    {carry_in, sel_four, rd_cmd, wr_cmd} = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_done();
    while (!mem_done) tick();
  endtask

  // place a value in MDR via a read of word 0, leaves MAR at 0
  task automatic put_mdr(logic [W-1:0] v);
    mem[0] = v;
    idle(); mar_ld = 1'b1; tick();
    idle(); rd_cmd = 1'b1; tick();
    idle(); wait_done();
    mdr_mem_ld = 1'b1; tick();
    idle();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(WDOG_CYC * 8);
    n_bad++;
    $display("FAIL watchdog R10 actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    idle();
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 / R2 / R11 reset state
    check("R1 mem_addr", mem_addr, '0);
    check("R11 ir_q", ir_q, '0);
    check("R1 strobes", {30'd0, mem_rd, mem_wr}, '0);
    check("R2 idle bus", bus_q, '0);
    pc_drv = 1'b1; #1;
    check("R1 pc zero", bus_q, '0);
    idle();

    // R12 fetch twice, PC steps by 4
    mem[0] = 32'hA5A5_0001;
    mem[1] = 32'h5A5A_0002;
    for (int f = 0; f < 2; f++) begin
      lat = 2 + f;
      idle(); pc_drv = 1'b1; mar_ld = 1'b1; rd_cmd = 1'b1;
      sel_four = 1'b1; alu_op = 2'b00; z_ld = 1'b1; tick();
      idle(); z_drv = 1'b1; pc_ld = 1'b1; y_ld = 1'b1; tick();
      check("R7 fetch addr", mem_addr, W'(4 * f));
      check("R10 read strobe held", {31'd0, mem_rd}, 32'd1);
      idle(); wait_done();
      mdr_mem_ld = 1'b1; tick();
      check("R10 read strobe dropped", {31'd0, mem_rd}, 32'd0);
      idle(); mdr_drv = 1'b1; ir_ld = 1'b1; tick();
      check("R12 ir fetched", ir_q, (f == 0) ? 32'hA5A5_0001 : 32'h5A5A_0002);
      idle(); pc_drv = 1'b1; #1;
      check("R12 pc advanced", bus_q, W'(4 * (f + 1)));
      idle();
    end

    // R5 / R6 ALU table
    lat = 0;
    for (int k = 0; k < 8; k++) begin
      put_mdr(VEC[k][95:64]);
      mdr_drv = 1'b1; y_ld = 1'b1; tick();
      idle();
      put_mdr(VEC[k][63:32]);
      mdr_drv = 1'b1; alu_op = VEC[k][99:98]; carry_in = VEC[k][97];
      sel_four = VEC[k][96]; z_ld = 1'b1; tick();
      idle(); z_drv = 1'b1; #1;
      check(VEC[k][96] ? "R5 const four" : "R6 alu op", bus_q, VEC[k][31:0]);
      idle();
    end

    // R4 general registers, one-hot select
    lat = 1;
    for (int i = 0; i < NREG; i++) begin
      put_mdr(32'h1111_0000 + W'(i * 32'h0101));
      mdr_drv = 1'b1; gpr_ld[i] = 1'b1; tick();
      idle();
    end
    for (int i = 0; i < NREG; i++) begin
      gpr_drv[i] = 1'b1; #1;
      check("R4 gpr readback", bus_q, 32'h1111_0000 + W'(i * 32'h0101));
      idle();
    end

    // R3 conflict flag
    pc_drv = 1'b1; #1;
    check("R3 single driver", {31'd0, bus_err}, 32'd0);
    z_drv = 1'b1; #1;
    check("R3 two drivers", {31'd0, bus_err}, 32'd1);
    idle(); gpr_drv = 8'h03; #1;
    check("R3 two gprs", {31'd0, bus_err}, 32'd1);
    idle();

    // R8 memory load wins over bus load
    lat = 2;
    put_mdr(32'hCAFE_F00D);
    mdr_drv = 1'b1; tmp_ld = 1'b1; tick();
    idle(); mem[0] = 32'h0BAD_BEEF; rd_cmd = 1'b1; tick();
    idle(); wait_done();
    mdr_mem_ld = 1'b1; mdr_ld = 1'b1; tmp_drv = 1'b1; tick();
    idle(); mdr_drv = 1'b1; #1;
    check("R8 memory path priority", bus_q, 32'h0BAD_BEEF);
    idle();

    // R9 / R10 write path to word 2
    lat = 3;
    mem[2] = '0;
    put_mdr(32'h0000_0008);
    mdr_drv = 1'b1; tmp_ld = 1'b1; tick();
    idle();
    put_mdr(32'hDEAD_0042);
    check("R9 wdata gated", mem_wdata, '0);
    tmp_drv = 1'b1; mar_ld = 1'b1; tick();
    idle(); wr_cmd = 1'b1; mdr_mem_drv = 1'b1; tick();
    wr_cmd = 1'b0;
    check("R9 wdata driven", mem_wdata, 32'hDEAD_0042);
    check("R10 write strobe", {31'd0, mem_wr}, 32'd1);
    wait_done();
    tick();
    check("R10 write done", {31'd0, mem_wr}, 32'd0);
    check("R10 memory written", mem[2], 32'hDEAD_0042);
    idle();

    // R1 reset mid-run
    rst = 1'b1; tick(); rst = 1'b0;
    check("R1 ir cleared", ir_q, '0);
    check("R1 mar cleared", mem_addr, '0);
    z_drv = 1'b1; #1;
    check("R1 z cleared", bus_q, '0);
    idle(); gpr_drv = 8'h80; #1;
    check("R1 gpr cleared", bus_q, '0);
    idle();

    summary();
    $finish;
  end
endmodule